// File: doc/BRIEF.md
# ATA Task-File Register Channel

This block is the register front end of one parallel ATA channel with two device slots. A host reaches it through a byte-wide access port. Offsets 1 to 7 select the command-block registers and offset 8 selects the device-control register. Each slot has a static configuration input that marks it as a disk, an optical drive or empty. The block holds sector count, sector number and a 16-bit cylinder for each drive. It also holds one set of channel-wide registers: error, features, drive/head, status, command and device control.

The block sequences a software reset from the edges of the reset bit in device control. On the release edge it loads a per-drive signature that depends on the slot type. It routes the drive-specific accesses by the drive-select bit, and it flags the selection of an empty slot. Command execution, the data port, DMA, interrupt delivery and storage are outside the block. The features, command and device-control bytes are driven out to the logic that does that work.

Top module: `ata_tf_channel`

## Requirements
- R1: An access with `acc_size` other than 0 (0 means one byte) raises `bad_size` in the following cycle. It changes no register, and if it is a read it returns 0x00.
- R2: After reset: error 0x01, drive/head 0x00, status 0x00, command 0x00, device control 0x08 and features 0x00. Each drive holds sector count 0x01, sector number 0x01 and cylinder 0x0000.
- R3: A device-control write whose bit 2 (soft reset) goes from 0 to 1 loads status 0x90 and error 0x01 and clears the command register. Every device-control write stores the written byte. Writing bit 2 as 1 while it is already 1 starts nothing.
- R4: A device-control write whose bit 2 goes from 1 to 0 does the following. It clears status bit 7 (busy), sets status bit 6 (ready) and zeroes drive/head bits 3:0. It gives both drives sector count 0x01 and sector number 0x01. It loads cylinder 0xEB14 into an optical slot and 0x0000 into any other slot.
- R5: A write to offset 6 (drive/head) stores the written value OR 0xA0.
- R6: The slot type of slot n is `slot_type[2n+1:2n]`: 00 is disk, 01 is optical, and 10 or 11 is empty. Take the slot named by bit 4 of the byte written to drive/head. If that slot is empty, error bit 2 (abort) and status bit 0 (error) are set.
- R7: Drive/head bit 4 selects which drive's sector count, sector number and cylinder are read and written.
- R8: Offset 2 accesses sector count and offset 3 accesses sector number. Offset 4 accesses the low cylinder byte and offset 5 the high cylinder byte. Each write changes only its own register.
- R9: Offset 1 writes features and reads error. Offset 7 writes command and reads status. Offset 8 writes device control and reads status.
- R10: Offsets 0 and 9 to 15 are unmapped. A read of one returns 0x00 and a write to one is ignored. Either access raises `bad_offset` for exactly one cycle.
- R11: A read gives `rd_valid` with `rd_data` in the cycle after the access. A write updates the registers and the byte outputs at the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_type | input | 4 | Static type of slot 0 (bits 1:0) and slot 1 (bits 3:2) |
| acc_valid | input | 1 | Host access in this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_ofs | input | 4 | Register offset |
| acc_size | input | 2 | Access size code, 0 = single byte |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 8 | Read result |
| bad_size | output | 1 | One-cycle flag for an access that is not a single byte |
| bad_offset | output | 1 | One-cycle flag for an access to an unmapped offset |
| feat_byte | output | 8 | Features register |
| cmd_byte | output | 8 | Command register |
| devctl_byte | output | 8 | Device-control register |

## Verification
Register writes take effect at the clock edge that captures the access. Read data and both error flags are registered, so they appear one cycle after the access. The driver task applies each access at a falling edge. It queues the read data and flags expected from that access. The monitor samples 5 ns after the next rising edge and compares against the head of the queue. In cycles with no access, the monitor checks that `rd_valid` and both flags are low. The byte outputs are checked at the falling edge after a write. That falls half a cycle after the capturing edge.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

   // slot type codes
   localparam logic [1:0] SLOT_DISK    = 2'b00;
   localparam logic [1:0] SLOT_OPTICAL = 2'b01;

   // register offsets
   localparam int OFS_FEAT_ERR = 1;
   localparam int OFS_SCNT     = 2;
   localparam int OFS_SNUM     = 3;
   localparam int OFS_CYL_LO   = 4;
   localparam int OFS_CYL_HI   = 5;
   localparam int OFS_DRVHD    = 6;
   localparam int OFS_CMD_STAT = 7;
   localparam int OFS_DEVCTL   = 8;

   // bit positions
   localparam int DH_DRV_BIT = 4;
   localparam int DH_HEAD_W  = 4;
   localparam int ST_BSY     = 7;
   localparam int ST_DRDY    = 6;
   localparam int ST_ERR     = 0;
   localparam int ER_ABRT    = 2;
   localparam int DC_SRST    = 2;

   // constant values
   localparam logic [7:0] DH_FORCE_ONES = 8'hA0;
   localparam logic [7:0] ST_RESETTING  = 8'h90;
   localparam logic [7:0] ER_DIAG_OK    = 8'h01;
   localparam logic [7:0] DC_POWER_ON   = 8'h08;
   localparam logic [15:0] CYL_SIG_OPTICAL = 16'hEB14;
   localparam logic [15:0] CYL_SIG_OTHER   = 16'h0000;

   typedef struct packed {
      logic feat;
      logic scnt;
      logic snum;
      logic cyl_lo;
      logic cyl_hi;
      logic drvhd;
      logic cmd;
      logic devctl;
   } tf_hit_t;

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
   import ata_tf_pkg::*;
#(
   parameter int OFS_W  = 4,
   parameter int SIZE_W = 2
)(
   input  logic              acc_valid,
   input  logic              acc_we,
   input  logic [OFS_W-1:0]  acc_ofs,
   input  logic [SIZE_W-1:0] acc_size,
   output tf_hit_t           wr_hit,
   output tf_hit_t           rd_hit,
   output logic              size_bad,
   output logic              ofs_bad
);

   logic    size_ok;
   tf_hit_t hit;

   assign size_ok = acc_valid && (acc_size == '0);

   always_comb begin
      hit        = '0;
      hit.feat   = (acc_ofs == OFS_W'(OFS_FEAT_ERR));
      hit.scnt   = (acc_ofs == OFS_W'(OFS_SCNT));
      hit.snum   = (acc_ofs == OFS_W'(OFS_SNUM));
      hit.cyl_lo = (acc_ofs == OFS_W'(OFS_CYL_LO));
      hit.cyl_hi = (acc_ofs == OFS_W'(OFS_CYL_HI));
      hit.drvhd  = (acc_ofs == OFS_W'(OFS_DRVHD));
      hit.cmd    = (acc_ofs == OFS_W'(OFS_CMD_STAT));
      hit.devctl = (acc_ofs == OFS_W'(OFS_DEVCTL));
   end

   assign wr_hit   = (size_ok &&  acc_we) ? hit : '0;
   assign rd_hit   = (size_ok && !acc_we) ? hit : '0;
   assign size_bad = acc_valid && (acc_size != '0);
   assign ofs_bad  = size_ok && (hit == '0);

endmodule

// File: rtl/ata_tf_drive_regs.sv
module ata_tf_drive_regs
   import ata_tf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CYL_W  = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        kind,
   input  logic              selected,
   input  logic              wr_scnt,
   input  logic              wr_snum,
   input  logic              wr_cyl_lo,
   input  logic              wr_cyl_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rst_release,
   output logic [DATA_W-1:0] scnt_q,
   output logic [DATA_W-1:0] snum_q,
   output logic [CYL_W-1:0]  cyl_q
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [CYL_W-1:0] cyl_sig;

   assign cyl_sig = (kind == SLOT_OPTICAL) ? CYL_W'(CYL_SIG_OPTICAL)
                                           : CYL_W'(CYL_SIG_OTHER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scnt_q <= ONE;
         snum_q <= ONE;
         cyl_q  <= '0;
      end else if (rst_release) begin
         scnt_q <= ONE;
         snum_q <= ONE;
         cyl_q  <= cyl_sig;
      end else if (selected) begin
         if (wr_scnt)   scnt_q <= wdata;
         if (wr_snum)   snum_q <= wdata;
         if (wr_cyl_lo) cyl_q[DATA_W-1:0] <= wdata;
         if (wr_cyl_hi) cyl_q[CYL_W-1:DATA_W] <= wdata;
      end
   end

endmodule

// File: rtl/ata_tf_shared_regs.sv
module ata_tf_shared_regs
   import ata_tf_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_feat,
   input  logic              wr_drvhd,
   input  logic              wr_cmd,
   input  logic              wr_devctl,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sel_absent,
   output logic              rst_release,
   output logic [DATA_W-1:0] err_q,
   output logic [DATA_W-1:0] feat_q,
   output logic [DATA_W-1:0] dh_q,
   output logic [DATA_W-1:0] stat_q,
   output logic [DATA_W-1:0] cmd_q,
   output logic [DATA_W-1:0] dc_q
);

   logic rst_entry;

   assign rst_entry   = wr_devctl && !dc_q[DC_SRST] &&  wdata[DC_SRST];
   assign rst_release = wr_devctl &&  dc_q[DC_SRST] && !wdata[DC_SRST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= DATA_W'(ER_DIAG_OK);
         feat_q <= '0;
         dh_q   <= '0;
         stat_q <= '0;
         cmd_q  <= '0;
         dc_q   <= DATA_W'(DC_POWER_ON);
      end else begin
         if (wr_feat) feat_q <= wdata;
         if (wr_cmd)  cmd_q  <= wdata;
         if (wr_devctl) begin
            dc_q <= wdata;
            if (rst_entry) begin
               stat_q <= DATA_W'(ST_RESETTING);
               err_q  <= DATA_W'(ER_DIAG_OK);
               cmd_q  <= '0;
            end
            if (rst_release) begin
               stat_q[ST_BSY]          <= 1'b0;
               stat_q[ST_DRDY]         <= 1'b1;
               dh_q[DH_HEAD_W-1:0]     <= '0;
            end
         end
         if (wr_drvhd) begin
            dh_q <= wdata | DATA_W'(DH_FORCE_ONES);
            if (sel_absent) begin
               err_q[ER_ABRT] <= 1'b1;
               stat_q[ST_ERR] <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ata_tf_channel.sv
module ata_tf_channel
   import ata_tf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int NUM_SLOTS = 2,
   parameter int OFS_W     = 4,
   parameter int SIZE_W    = 2,
   parameter int CYL_W     = 16
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2*NUM_SLOTS-1:0] slot_type,
   input  logic                   acc_valid,
   input  logic                   acc_we,
   input  logic [OFS_W-1:0]       acc_ofs,
   input  logic [SIZE_W-1:0]      acc_size,
   input  logic [DATA_W-1:0]      acc_wdata,
   output logic                   rd_valid,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   bad_size,
   output logic                   bad_offset,
   output logic [DATA_W-1:0]      feat_byte,
   output logic [DATA_W-1:0]      cmd_byte,
   output logic [DATA_W-1:0]      devctl_byte
);

   localparam int SEL_W = $clog2(NUM_SLOTS);

   if (DATA_W != 8) begin : g_chk_data_w
      $error("ata_tf_channel: DATA_W must be 8");
   end
   if (NUM_SLOTS != 2) begin : g_chk_slots
      $error("ata_tf_channel: drive select is one bit, NUM_SLOTS must be 2");
   end
   if (CYL_W != 2 * DATA_W) begin : g_chk_cyl
      $error("ata_tf_channel: CYL_W must be two bytes");
   end
   if (OFS_W < 4) begin : g_chk_ofs
      $error("ata_tf_channel: OFS_W must reach offset 8");
   end

   tf_hit_t           wr_hit, rd_hit;
   logic              size_bad, ofs_bad;
   logic              rst_release, sel_absent;
   logic [DATA_W-1:0] err_q, feat_q, dh_q, stat_q, cmd_q, dc_q;
   logic [SEL_W-1:0]  dsel, new_sel;
   logic [1:0]        kind_a [NUM_SLOTS];
   logic [DATA_W-1:0] scnt_a [NUM_SLOTS];
   logic [DATA_W-1:0] snum_a [NUM_SLOTS];
   logic [CYL_W-1:0]  cyl_a  [NUM_SLOTS];
   logic [DATA_W-1:0] rd_next;

   ata_tf_decode #(.OFS_W(OFS_W), .SIZE_W(SIZE_W)) u_decode (
      .acc_valid (acc_valid),
      .acc_we    (acc_we),
      .acc_ofs   (acc_ofs),
      .acc_size  (acc_size),
      .wr_hit    (wr_hit),
      .rd_hit    (rd_hit),
      .size_bad  (size_bad),
      .ofs_bad   (ofs_bad)
   );

   assign dsel       = dh_q[DH_DRV_BIT +: SEL_W];
   assign new_sel    = acc_wdata[DH_DRV_BIT +: SEL_W];
   assign sel_absent = kind_a[new_sel][1];

   ata_tf_shared_regs #(.DATA_W(DATA_W)) u_shared (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_feat     (wr_hit.feat),
      .wr_drvhd    (wr_hit.drvhd),
      .wr_cmd      (wr_hit.cmd),
      .wr_devctl   (wr_hit.devctl),
      .wdata       (acc_wdata),
      .sel_absent  (sel_absent),
      .rst_release (rst_release),
      .err_q       (err_q),
      .feat_q      (feat_q),
      .dh_q        (dh_q),
      .stat_q      (stat_q),
      .cmd_q       (cmd_q),
      .dc_q        (dc_q)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign kind_a[s] = slot_type[2*s +: 2];

      ata_tf_drive_regs #(.DATA_W(DATA_W), .CYL_W(CYL_W)) u_drive (
         .clk         (clk),
         .rst_n       (rst_n),
         .kind        (kind_a[s]),
         .selected    (dsel == SEL_W'(s)),
         .wr_scnt     (wr_hit.scnt),
         .wr_snum     (wr_hit.snum),
         .wr_cyl_lo   (wr_hit.cyl_lo),
         .wr_cyl_hi   (wr_hit.cyl_hi),
         .wdata       (acc_wdata),
         .rst_release (rst_release),
         .scnt_q      (scnt_a[s]),
         .snum_q      (snum_a[s]),
         .cyl_q       (cyl_a[s])
      );
   end

   always_comb begin
      rd_next = '0;
      if (rd_hit.feat)   rd_next = err_q;
      if (rd_hit.scnt)   rd_next = scnt_a[dsel];
      if (rd_hit.snum)   rd_next = snum_a[dsel];
      if (rd_hit.cyl_lo) rd_next = cyl_a[dsel][DATA_W-1:0];
      if (rd_hit.cyl_hi) rd_next = cyl_a[dsel][CYL_W-1:DATA_W];
      if (rd_hit.drvhd)  rd_next = dh_q;
      if (rd_hit.cmd)    rd_next = stat_q;
      if (rd_hit.devctl) rd_next = stat_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         bad_size   <= 1'b0;
         bad_offset <= 1'b0;
      end else begin
         rd_valid   <= acc_valid && !acc_we;
         rd_data    <= rd_next;
         bad_size   <= size_bad;
         bad_offset <= ofs_bad;
      end
   end

   assign feat_byte   = feat_q;
   assign cmd_byte    = cmd_q;
   assign devctl_byte = dc_q;

endmodule

// File: rtl/ata_tf_channel_chk.sv
module ata_tf_channel_chk #(
   parameter int DATA_W    = 8,
   parameter int NUM_SLOTS = 2,
   parameter int OFS_W     = 4,
   parameter int SIZE_W    = 2
)(
   input logic                   clk,
   input logic                   rst_n,
   input logic [2*NUM_SLOTS-1:0] slot_type,
   input logic                   acc_valid,
   input logic                   acc_we,
   input logic [OFS_W-1:0]       acc_ofs,
   input logic [SIZE_W-1:0]      acc_size,
   input logic [DATA_W-1:0]      acc_wdata,
   input logic                   rd_valid,
   input logic                   bad_size,
   input logic                   bad_offset,
   input logic [DATA_W-1:0]      err_q,
   input logic [DATA_W-1:0]      dh_q,
   input logic [DATA_W-1:0]      stat_q,
   input logic [DATA_W-1:0]      cmd_q,
   input logic [DATA_W-1:0]      dc_q
);

   logic good_wr, dc_wr, dh_wr, unmapped, new_absent;

   assign good_wr    = acc_valid && acc_we && (acc_size == '0);
   assign dc_wr      = good_wr && (acc_ofs == OFS_W'(8));
   assign dh_wr      = good_wr && (acc_ofs == OFS_W'(6));
   assign unmapped   = (acc_ofs == '0) || (acc_ofs > OFS_W'(8));
   assign new_absent = acc_wdata[4] ? slot_type[3] : slot_type[1];

   assert_size_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_size != '0) |=> (bad_size && $stable(dh_q) && $stable(stat_q)
                                         && $stable(err_q) && $stable(dc_q)));

   assert_reset_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dc_wr && !dc_q[2] && acc_wdata[2]) |=> (stat_q == 8'h90 && err_q == 8'h01 && cmd_q == '0));

   assert_reset_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dc_wr && dc_q[2] && !acc_wdata[2]) |=> (!stat_q[7] && stat_q[6] && dh_q[3:0] == '0));

   assert_dh_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dh_wr |=> (dh_q[7] && dh_q[5]));

   assert_absent_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dh_wr && new_absent) |=> (err_q[2] && stat_q[0]));

   assert_unmapped_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_size == '0 && unmapped) |=> bad_offset);

   assert_flag_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!bad_offset && !bad_size && !rd_valid));

   assert_read_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_we) |=> rd_valid);

endmodule

bind ata_tf_channel ata_tf_channel_chk #(
   .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .OFS_W(OFS_W), .SIZE_W(SIZE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .slot_type(slot_type),
   .acc_valid(acc_valid), .acc_we(acc_we), .acc_ofs(acc_ofs),
   .acc_size(acc_size), .acc_wdata(acc_wdata),
   .rd_valid(rd_valid), .bad_size(bad_size), .bad_offset(bad_offset),
   .err_q(err_q), .dh_q(dh_q), .stat_q(stat_q), .cmd_q(cmd_q), .dc_q(dc_q)
);

// File: tb/ata_tf_channel_tb.sv
module ata_tf_channel_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] slot_type = 4'b0001;   // slot0 optical, slot1 disk
   logic       acc_valid = 1'b0;
   logic       acc_we = 1'b0;
   logic [3:0] acc_ofs = '0;
   logic [1:0] acc_size = '0;
   logic [7:0] acc_wdata = '0;
   logic       rd_valid, bad_size, bad_offset;
   logic [7:0] rd_data, feat_byte, cmd_byte, devctl_byte;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   typedef struct {
      bit       is_rd;
      bit [7:0] data;
      bit       bsz;
      bit       bofs;
      string    req;
   } exp_t;

   exp_t sb_q[$];

   always #10 clk = ~clk;   // 50 MHz

   ata_tf_channel u_dut (
      .clk(clk), .rst_n(rst_n), .slot_type(slot_type),
      .acc_valid(acc_valid), .acc_we(acc_we), .acc_ofs(acc_ofs),
      .acc_size(acc_size), .acc_wdata(acc_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .bad_size(bad_size), .bad_offset(bad_offset),
      .feat_byte(feat_byte), .cmd_byte(cmd_byte), .devctl_byte(devctl_byte)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // driver: one access, expected result queued for the monitor
   task automatic access(input bit we, input int ofs, input int sz, input logic [7:0] wd,
                         input logic [7:0] exp_d, input bit e_sz, input bit e_ofs,
                         input string req);
      exp_t e;
      @(negedge clk);
      acc_valid = 1'b1; acc_we = we; acc_ofs = 4'(ofs); acc_size = 2'(sz); acc_wdata = wd;
      e.is_rd = !we; e.data = exp_d; e.bsz = e_sz; e.bofs = e_ofs; e.req = req;
      sb_q.push_back(e);
      @(negedge clk);
      acc_valid = 1'b0; acc_we = 1'b0;
   endtask

   task automatic wr(input int ofs, input logic [7:0] wd, input string req);
      access(1'b1, ofs, 0, wd, 8'h00, 1'b0, 1'b0, req);
   endtask

   task automatic rd(input int ofs, input logic [7:0] exp_d, input string req);
      access(1'b0, ofs, 0, 8'h00, exp_d, 1'b0, 1'b0, req);
   endtask

   // monitor: results due one cycle after the access
   always begin
      bit took;
      exp_t e;
      @(posedge clk);
      took = acc_valid;
      #5;
      if (took) begin
         if (sb_q.size() == 0) begin
            n_vec++; n_fail++;
            $display("FAIL R11: actual result with no expected item, expected empty queue");
         end else begin
            e = sb_q.pop_front();
            chk(rd_valid, e.is_rd, {e.req, " rd_valid"});
            if (e.is_rd) chk(rd_data, e.data, {e.req, " rd_data"});
            chk(bad_size, e.bsz, {e.req, " bad_size"});
            chk(bad_offset, e.bofs, {e.req, " bad_offset"});
         end
      end else if (rst_n) begin
         chk({rd_valid, bad_size, bad_offset}, 3'b000, "R10 idle pulses");
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 power-on values
      @(negedge clk);
      chk(devctl_byte, 8'h08, "R2 devctl");
      chk(cmd_byte, 8'h00, "R2 cmd");
      chk(feat_byte, 8'h00, "R2 feat");
      rd(1, 8'h01, "R2 error");
      rd(6, 8'h00, "R2 drvhd");
      rd(7, 8'h00, "R2 status");
      rd(2, 8'h01, "R2 scnt");
      rd(3, 8'h01, "R2 snum");
      rd(4, 8'h00, "R2 cyl lo");
      rd(5, 8'h00, "R2 cyl hi");

      // R9 split offsets
      wr(1, 8'h5A, "R9 feat write");
      chk(feat_byte, 8'h5A, "R9 feat_byte");
      rd(1, 8'h01, "R9 offset1 reads error");
      wr(7, 8'hEC, "R9 cmd write");
      chk(cmd_byte, 8'hEC, "R9 cmd_byte");
      rd(7, 8'h00, "R9 offset7 reads status");
      rd(8, 8'h00, "R9 offset8 reads status");

      // R8 drive 0 registers, sector number write touches nothing else
      wr(2, 8'h11, "R8 scnt"); wr(4, 8'h33, "R8 cyl lo");
      wr(5, 8'h44, "R8 cyl hi"); wr(3, 8'h22, "R8 snum");
      rd(2, 8'h11, "R8 scnt"); rd(3, 8'h22, "R8 snum");
      rd(4, 8'h33, "R8 cyl lo after snum write"); rd(5, 8'h44, "R8 cyl hi");

      // R5 / R7 select drive 1
      wr(6, 8'h10, "R5 drvhd write");
      rd(6, 8'hB0, "R5 forced ones");
      rd(1, 8'h01, "R6 present slot no abort");
      rd(2, 8'h01, "R7 drive1 scnt untouched");
      wr(2, 8'h55, "R7"); wr(3, 8'h66, "R7"); wr(4, 8'h77, "R7"); wr(5, 8'h88, "R7");
      rd(2, 8'h55, "R7 drive1 scnt"); rd(5, 8'h88, "R7 drive1 cyl hi");
      wr(6, 8'h00, "R5 drvhd write");
      rd(6, 8'hA0, "R5 forced ones on zero");
      rd(2, 8'h11, "R7 back to drive0 scnt");
      rd(4, 8'h33, "R7 back to drive0 cyl lo");

      // R1 bad size
      access(1'b1, 2, 1, 8'h99, 8'h00, 1'b1, 1'b0, "R1 write size 2");
      access(1'b1, 8, 2, 8'h04, 8'h00, 1'b1, 1'b0, "R1 devctl write size 4");
      chk(devctl_byte, 8'h08, "R1 devctl unchanged");
      rd(2, 8'h11, "R1 scnt unchanged");
      access(1'b0, 1, 2, 8'h00, 8'h00, 1'b1, 1'b0, "R1 read returns zero");

      // R10 unmapped
      access(1'b1, 9, 0, 8'hFF, 8'h00, 1'b0, 1'b1, "R10 write ofs 9");
      access(1'b1, 0, 0, 8'h12, 8'h00, 1'b0, 1'b1, "R10 write ofs 0");
      access(1'b0, 9, 0, 8'h00, 8'h00, 1'b0, 1'b1, "R10 read ofs 9");
      access(1'b0, 15, 0, 8'h00, 8'h00, 1'b0, 1'b1, "R10 read ofs 15");
      chk(cmd_byte, 8'hEC, "R10 cmd unchanged");
      chk(feat_byte, 8'h5A, "R10 feat unchanged");
      rd(6, 8'hA0, "R10 drvhd unchanged");

      // R3 reset entry
      wr(6, 8'h0F, "R5 set head");
      wr(8, 8'h04, "R3 srst rise");
      chk(devctl_byte, 8'h04, "R3 devctl stored");
      chk(cmd_byte, 8'h00, "R3 cmd cleared");
      rd(8, 8'h90, "R3 status 0x90");
      rd(1, 8'h01, "R3 error 0x01");
      wr(7, 8'h20, "R3 cmd during reset");
      wr(8, 8'h06, "R3 srst held, no edge");
      chk(cmd_byte, 8'h20, "R3 no second entry");
      chk(devctl_byte, 8'h06, "R3 devctl stored");

      // R4 reset release
      wr(8, 8'h02, "R4 srst fall");
      chk(devctl_byte, 8'h02, "R4 devctl stored");
      rd(8, 8'h50, "R4 status ready");
      rd(6, 8'hA0, "R4 head zeroed");
      rd(2, 8'h01, "R4 drive0 scnt");
      rd(3, 8'h01, "R4 drive0 snum");
      rd(4, 8'h14, "R4 optical cyl lo");
      rd(5, 8'hEB, "R4 optical cyl hi");
      wr(6, 8'h10, "R7 select drive1");
      rd(2, 8'h01, "R4 drive1 scnt");
      rd(3, 8'h01, "R4 drive1 snum");
      rd(4, 8'h00, "R4 disk cyl lo");
      rd(5, 8'h00, "R4 disk cyl hi");

      // R6 absent slot
      @(negedge clk);
      slot_type = 4'b1001;   // slot1 absent
      wr(6, 8'h00, "R6 select present slot0");
      rd(1, 8'h01, "R6 no abort for present slot");
      wr(6, 8'h10, "R6 select absent slot1");
      rd(1, 8'h05, "R6 abort bit");
      rd(7, 8'h51, "R6 status error bit");

      repeat (3) @(negedge clk);
      chk(sb_q.size(), 0, "R11 all results seen");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule